// File: doc/BRIEF.md
# Instruction-Count Debug Trigger Bank

This block holds a bank of debug triggers that count retired instructions. Each trigger keeps one control word. The word holds a type field, a remaining-instruction count, and enable bits for each privilege level, including the two virtualized levels. When an instruction retires, every trigger of the instruction-count type with a non-zero count checks its enable bits against the current privilege level. If the level is enabled, the count drops by one. The step that takes a count from one to zero raises that trigger's action line for a single cycle. The debug logic of the core uses that line to stop or trap.

Software reaches the bank through three registers: a select register, the data-1 control word of the selected trigger, and the data-2/data-3 slots, which do nothing for this trigger type. A write to data-1 is legalized, so only the type, the mode bits and the count survive. A read of data-1 returns the stored word, and its count field is the live remaining count.

Top module: `icount_trig_unit`

## Requirements
- R1: After reset every control word reads zero, every action line is low and the select register reads zero.
- R2: A data-1 write stores only bits 31:28 (type), 26 (VU enable), 25 (VS enable), 23:10 (14-bit count), 9 (M enable), 7 (S enable) and 6 (U enable). Every other bit, including the hit bit 24, the pending bit 8 and the action bits 5:0, reads back zero.
- R3: Writes to csr_addr 2 or 3 (data-2, data-3) change no control word, and reads of those addresses return zero. csr_addr 0 is select and 1 is data-1.
- R4: With virt_i low, a retire at privilege priv_i (0 U, 1 S, 3 M, 2 none) decrements an armed trigger exactly when the enable bit for that level is set.
- R5: With virt_i high, only VS (priv_i 1) and VU (priv_i 0) are checked. The M, S and U bits have no effect.
- R6: With no retire, or when the privilege level does not match, the count is held.
- R7: A trigger whose count is zero never counts and never fires.
- R8: Only type value 3 counts. A word with any other type holds its count.
- R9: The decrement from one to zero drives that trigger's action_o bit high in the following cycle, for one cycle, together with the zero count. Any other decrement leaves the bit low.
- R10: All triggers step and fire independently in the same cycle.
- R11: A data-1 write to a trigger takes priority over a decrement in the same cycle. The written count is stored and no action is raised.
- R12: A select write with a value at or above the trigger count selects the highest trigger.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| retire_i | input | 1 | One instruction retires this cycle |
| priv_i | input | 2 | Current privilege level (0 U, 1 S, 3 M) |
| virt_i | input | 1 | Virtualization active |
| csr_we | input | 1 | Register write strobe |
| csr_addr | input | 2 | 0 select, 1 data-1, 2 data-2, 3 data-3 |
| csr_wdata | input | 32 | Write data |
| csr_rdata | output | 32 | Read data for csr_addr |
| action_o | output | NUM_TRIG | Per-trigger action pulse |

## Verification
Two functions can land on the same edge: a software write to data-1 of the selected trigger, and a retire that would decrement that same trigger. The bench makes them collide by asserting retire_i in the very cycle of the data-1 write, both on a count of two and on a count of one that is about to fire. It then reads back the written count and checks that action_o stayed low. A sweep over every privilege level, the virtualization flag and all 32 combinations of mode bits compares each decrement with an enable function that the bench computes on its own.

// File: rtl/icount_pkg.sv
package icount_pkg;
  localparam int XLEN     = 32;
  localparam int CNT_LSB  = 10;
  localparam int CNT_W    = 14;
  localparam int TYPE_W   = 4;
  localparam int TYPE_LSB = XLEN - TYPE_W;
  localparam int BIT_U    = 6;
  localparam int BIT_S    = 7;
  localparam int BIT_M    = 9;
  localparam int BIT_VS   = 25;
  localparam int BIT_VU   = 26;
  localparam logic [TYPE_W-1:0] TYPE_ICOUNT = 4'd3;

  typedef logic [XLEN-1:0]  word_t;
  typedef logic [CNT_W-1:0] cnt_t;

  typedef enum logic [1:0] {
    LVL_USER  = 2'd0,
    LVL_SUPER = 2'd1,
    LVL_RSVD  = 2'd2,
    LVL_MACH  = 2'd3
  } lvl_e;

  // Bits that survive a data-1 write
  function automatic word_t keep_mask();
    word_t m;
    m = '0;
    m[TYPE_LSB +: TYPE_W] = '1;
    m[CNT_LSB +: CNT_W]   = '1;
    m[BIT_U]  = 1'b1;
    m[BIT_S]  = 1'b1;
    m[BIT_M]  = 1'b1;
    m[BIT_VS] = 1'b1;
    m[BIT_VU] = 1'b1;
    return m;
  endfunction

  function automatic word_t legalize(word_t w);
    return w & keep_mask();
  endfunction

  function automatic cnt_t get_count(word_t w);
    return w[CNT_LSB +: CNT_W];
  endfunction

  function automatic word_t put_count(word_t w, cnt_t c);
    word_t r;
    r = w;
    r[CNT_LSB +: CNT_W] = c;
    return r;
  endfunction

  function automatic logic is_icount(word_t w);
    return w[TYPE_LSB +: TYPE_W] == TYPE_ICOUNT;
  endfunction

  // Privilege filter: virtual levels checked only when virtualization is on
  function automatic logic mode_hits(word_t w, logic [1:0] lvl, logic virt);
    logic h;
    h = 1'b0;
    if (virt) begin
      case (lvl_e'(lvl))
        LVL_SUPER: h = w[BIT_VS];
        LVL_USER:  h = w[BIT_VU];
        default:   h = 1'b0;
      endcase
    end else begin
      case (lvl_e'(lvl))
        LVL_MACH:  h = w[BIT_M];
        LVL_SUPER: h = w[BIT_S];
        LVL_USER:  h = w[BIT_U];
        default:   h = 1'b0;
      endcase
    end
    return h;
  endfunction
endpackage

// File: rtl/icount_slot.sv
module icount_slot
  import icount_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wr_en,
  input  word_t      wdata,
  input  logic       retire,
  input  logic [1:0] lvl,
  input  logic       virt,
  output word_t      word_o,
  output logic       action_o
);
  word_t word_q;
  logic  act_q;
  cnt_t  count;
  logic  armed;
  logic  lvl_hit;
  logic  cnt_step;
  logic  last_step;

  assign count     = get_count(word_q);
  assign armed     = is_icount(word_q) && (count != '0);
  assign lvl_hit   = mode_hits(word_q, lvl, virt);
  assign cnt_step  = retire && armed && lvl_hit && !wr_en;
  assign last_step = cnt_step && (count == cnt_t'(1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      word_q <= '0;
      act_q  <= 1'b0;
    end else if (wr_en) begin
      word_q <= legalize(wdata);
      act_q  <= 1'b0;
    end else if (cnt_step) begin
      word_q <= put_count(word_q, count - cnt_t'(1));
      act_q  <= last_step;
    end else begin
      act_q  <= 1'b0;
    end
  end

  assign word_o   = word_q;
  assign action_o = act_q;

  p_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (!wr_en && !(retire && lvl_hit)) |=> $stable(word_q));
  p_step_r4: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_step |=> (get_count(word_q) == $past(count) - cnt_t'(1)));
  p_idle_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (!wr_en && count == '0) |=> (get_count(word_q) == '0 && !action_o));
  p_fire_r9: assert property (@(posedge clk) disable iff (!rst_n)
    action_o |-> (get_count(word_q) == '0 && $past(retire) && !$past(wr_en)));
  p_type_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (!wr_en && !is_icount(word_q)) |=> $stable(word_q));
  p_wr_wins_r11: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> (!action_o && word_q == legalize($past(wdata))));
endmodule

// File: rtl/icount_csr_port.sv
module icount_csr_port
  import icount_pkg::*;
#(
  parameter int NUM_TRIG = 4,
  localparam int SEL_W = (NUM_TRIG > 1) ? $clog2(NUM_TRIG) : 1
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     csr_we,
  input  logic [1:0]               csr_addr,
  input  word_t                    csr_wdata,
  input  word_t [NUM_TRIG-1:0]     words,
  output logic  [NUM_TRIG-1:0]     wr_vec,
  output word_t                    csr_rdata
);
  localparam logic [1:0] A_SEL = 2'd0;
  localparam logic [1:0] A_D1  = 2'd1;

  logic [SEL_W-1:0] sel_q;

  function automatic logic [SEL_W-1:0] clamp_sel(word_t v);
    if (v >= word_t'(NUM_TRIG)) return SEL_W'(NUM_TRIG - 1);
    return v[SEL_W-1:0];
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sel_q <= '0;
    else if (csr_we && csr_addr == A_SEL) sel_q <= clamp_sel(csr_wdata);
  end

  for (genvar g = 0; g < NUM_TRIG; g++) begin : g_dec
    assign wr_vec[g] = csr_we && (csr_addr == A_D1) && (sel_q == SEL_W'(g));
  end

  always_comb begin
    csr_rdata = '0;
    case (csr_addr)
      A_SEL:   csr_rdata = word_t'(sel_q);
      A_D1:    csr_rdata = words[sel_q];
      default: csr_rdata = '0;
    endcase
  end

  p_wr_onehot_r11: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(wr_vec));
  p_sel_range_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (int'(sel_q) < NUM_TRIG));
endmodule

// File: rtl/icount_trig_unit.sv
module icount_trig_unit
  import icount_pkg::*;
#(
  parameter int NUM_TRIG = 4
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                retire_i,
  input  logic [1:0]          priv_i,
  input  logic                virt_i,
  input  logic                csr_we,
  input  logic [1:0]          csr_addr,
  input  logic [XLEN-1:0]     csr_wdata,
  output logic [XLEN-1:0]     csr_rdata,
  output logic [NUM_TRIG-1:0] action_o
);
  word_t [NUM_TRIG-1:0] words;
  logic  [NUM_TRIG-1:0] wr_vec;

  icount_csr_port #(.NUM_TRIG(NUM_TRIG)) u_port (
    .clk(clk), .rst_n(rst_n), .csr_we(csr_we), .csr_addr(csr_addr),
    .csr_wdata(csr_wdata), .words(words), .wr_vec(wr_vec),
    .csr_rdata(csr_rdata)
  );

  for (genvar g = 0; g < NUM_TRIG; g++) begin : g_slot
    icount_slot u_slot (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_vec[g]), .wdata(csr_wdata),
      .retire(retire_i), .lvl(priv_i), .virt(virt_i),
      .word_o(words[g]), .action_o(action_o[g])
    );
  end

  p_rsvd_bits_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (csr_we && csr_addr == 2'd1) |=> ((csr_rdata & ~keep_mask()) == '0 || csr_addr != 2'd1));
  p_d23_ignored_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (csr_we && csr_addr[1] && !retire_i) |=> $stable(words));
endmodule

// File: tb/icount_trig_unit_bench.sv
module icount_trig_unit_bench;
  localparam int CLK_PERIOD = 10;
  localparam int NT = 4;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          retire_i = 1'b0;
  logic [1:0]    priv_i = 2'd3;
  logic          virt_i = 1'b0;
  logic          csr_we = 1'b0;
  logic [1:0]    csr_addr = 2'd0;
  logic [31:0]   csr_wdata = '0;
  logic [31:0]   csr_rdata;
  logic [NT-1:0] action_o;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  icount_trig_unit #(.NUM_TRIG(NT)) u_icount_trig_unit (
    .clk(clk), .rst_n(rst_n), .retire_i(retire_i), .priv_i(priv_i),
    .virt_i(virt_i), .csr_we(csr_we), .csr_addr(csr_addr),
    .csr_wdata(csr_wdata), .csr_rdata(csr_rdata), .action_o(action_o)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  // Mode-bit encodings, from R2
  function automatic logic [31:0] mk(int typ, int cnt, bit m, bit s, bit u, bit vs, bit vu);
    return (32'(typ) << 28) | (32'(cnt) << 10) | (32'(m) << 9) | (32'(s) << 7) |
           (32'(u) << 6) | (32'(vs) << 25) | (32'(vu) << 26);
  endfunction

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic wr(logic [1:0] a, logic [31:0] d, bit ret = 1'b0);
    csr_we = 1'b1; csr_addr = a; csr_wdata = d; retire_i = ret;
    tick();
    csr_we = 1'b0; retire_i = 1'b0;
  endtask

  task automatic rd(logic [1:0] a, output logic [31:0] v);
    csr_addr = a;
    #1;
    v = csr_rdata;
  endtask

  task automatic retire_n(int n);
    for (int k = 0; k < n; k++) begin
      retire_i = 1'b1;
      tick();
    end
    retire_i = 1'b0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual hung expected done");
      $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    logic [31:0] v;
    logic [31:0] mask;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1: reset state
    chk("R1 action", 32'(action_o), 0);
    rd(2'd0, v); chk("R1 select", v, 0);
    for (int t = 0; t < NT; t++) begin
      wr(2'd0, 32'(t));
      rd(2'd1, v); chk("R1 word", v, 0);
    end
    wr(2'd0, 0);

    // R2: legalization
    mask = (32'hF << 28) | (32'h3FFF << 10) | (32'd1 << 26) | (32'd1 << 25) |
           (32'd1 << 9) | (32'd1 << 7) | (32'd1 << 6);
    wr(2'd1, 32'hFFFF_FFFF);
    rd(2'd1, v); chk("R2 all-ones", v, mask);
    wr(2'd1, 32'h0100_013F);
    rd(2'd1, v); chk("R2 hit/pend/action zero", v, 0);

    // R3: data-2/3 ignored
    wr(2'd1, mk(3, 9, 1, 0, 0, 0, 0));
    wr(2'd2, 32'hFFFF_FFFF);
    wr(2'd3, 32'h1234_5678);
    rd(2'd1, v); chk("R3 word held", v, mk(3, 9, 1, 0, 0, 0, 0));
    rd(2'd2, v); chk("R3 read d2", v, 0);
    rd(2'd3, v); chk("R3 read d3", v, 0);

    // R4 R5 R6: sweep level x virt x mode bits
    for (int vi = 0; vi < 2; vi++) begin
      for (int lv = 0; lv < 4; lv++) begin
        for (int mb = 0; mb < 32; mb++) begin
          bit hit;
          bit m_ = mb[0], s_ = mb[1], u_ = mb[2], vs_ = mb[3], vu_ = mb[4];
          if (vi == 1) hit = (lv == 1 && vs_) || (lv == 0 && vu_);
          else hit = (lv == 3 && m_) || (lv == 1 && s_) || (lv == 0 && u_);
          wr(2'd1, mk(3, 5, m_, s_, u_, vs_, vu_));
          priv_i = 2'(lv); virt_i = vi[0];
          tick();                       // no retire: R6 hold
          retire_n(1);
          rd(2'd1, v);
          chk(vi ? "R5 virt sweep" : "R4 level sweep", v,
              mk(3, hit ? 4 : 5, m_, s_, u_, vs_, vu_));
        end
      end
    end
    virt_i = 1'b0; priv_i = 2'd3;

    // R8: only type 3 counts
    for (int ty = 0; ty < 16; ty++) begin
      wr(2'd1, mk(ty, 3, 1, 1, 1, 1, 1));
      retire_n(1);
      rd(2'd1, v);
      chk("R8 type", v, mk(ty, (ty == 3) ? 2 : 3, 1, 1, 1, 1, 1));
    end

    // R7: zero count inactive
    wr(2'd1, mk(3, 0, 1, 1, 1, 1, 1));
    retire_n(4);
    rd(2'd1, v); chk("R7 zero held", v, mk(3, 0, 1, 1, 1, 1, 1));
    chk("R7 no action", 32'(action_o), 0);

    // R9: fire once on 1->0
    wr(2'd1, mk(3, 2, 1, 0, 0, 0, 0));
    retire_n(1);
    chk("R9 no early action", 32'(action_o), 0);
    retire_n(1);
    chk("R9 action", 32'(action_o), 1);
    rd(2'd1, v); chk("R9 zero count", v, mk(3, 0, 1, 0, 0, 0, 0));
    tick();
    chk("R9 one cycle", 32'(action_o), 0);
    retire_n(3);
    chk("R9 not again", 32'(action_o), 0);

    // R10: parallel triggers, counts 1,2,3,0 in M mode
    for (int t = 0; t < NT; t++) begin
      wr(2'd0, 32'(t));
      wr(2'd1, mk(3, (t == 3) ? 0 : t + 1, 1, 0, 0, 0, 0));
    end
    for (int step = 1; step <= 4; step++) begin
      logic [NT-1:0] ex;
      ex = '0;
      for (int t = 0; t < 3; t++) if (t + 1 == step) ex[t] = 1'b1;
      retire_n(1);
      chk("R10 parallel fire", 32'(action_o), 32'(ex));
    end

    // R11: write wins over same-cycle decrement
    wr(2'd0, 0);
    wr(2'd1, mk(3, 2, 1, 0, 0, 0, 0));
    wr(2'd1, mk(3, 7, 1, 0, 0, 0, 0), 1'b1);
    rd(2'd1, v); chk("R11 write kept", v, mk(3, 7, 1, 0, 0, 0, 0));
    wr(2'd1, mk(3, 1, 1, 0, 0, 0, 0));
    wr(2'd1, mk(3, 1, 1, 0, 0, 0, 0), 1'b1);
    chk("R11 no action", 32'(action_o), 0);
    rd(2'd1, v); chk("R11 count one", v, mk(3, 1, 1, 0, 0, 0, 0));

    // R12: select clamps
    wr(2'd0, 32'd9);
    rd(2'd0, v); chk("R12 clamp", v, NT - 1);
    wr(2'd0, 32'h8000_0001);
    rd(2'd0, v); chk("R12 clamp high", v, NT - 1);
    wr(2'd0, 32'd2);
    rd(2'd0, v); chk("R12 in range", v, 2);

    done = 1'b1;
    $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule